// File: doc/BRIEF.md
# Pointer-Addressed Buffer RAM Port

This block lets a host reach a 2048-byte buffer memory through three small registers rather than a wide address bus. The host loads an 11-bit pointer split across a low register and a high register, then moves bytes through a single data register. The high register also carries two mode bits. One bit sets the transfer direction. The other turns on stepping of the pointer, so the host can fill or drain a buffer in order; with stepping off, the pointer stays put for random access.

For reads the block prefetches. Loading the pointer low byte while the direction bit selects reading starts a memory fetch. In stepping mode, each data read also advances the pointer and fetches the next byte. For writes, the byte first lands in the data register and is committed to memory one cycle later, at the pointer address. A pending commit wins over a fetch if both want the memory in the same cycle. Every host access finishes in the cycle its strobe is high, and the block has no stall signal.

Top module: `bufram_port`

## Requirements
- R1: After reset, the pointer is 0, both mode bits are 0, and reads of every register return 0x00.
- R2: Register select 1 reads and writes pointer bits 7:0. Select 2 holds pointer bits 10:8 in bits 2:0, the read-direction bit in bit 6 and the stepping-enable bit in bit 7, and its other bits read as 0. Select 3 reads as 0x00.
- R3: A write to select 1 while the read-direction bit is 1 fetches the byte at the new pointer. A data read (select 0) issued two or more cycles later returns that byte.
- R4: With stepping off, repeated data reads return the same byte and leave the pointer unchanged.
- R5: A data write stores the byte at the current pointer address one cycle after the write strobe. With stepping off, the pointer does not change.
- R6: With stepping on, each data write commits the byte and then advances the pointer by one, so consecutive writes fill consecutive addresses.
- R7: With stepping on, each data read returns the current byte, advances the pointer by one and fetches the next byte. That byte is readable two cycles later.
- R8: The pointer steps from 2047 to 0.
- R9: A write to select 1 while the read-direction bit is 0 fetches nothing, and the data register keeps its previous byte.
- R10: The read value appears on host_rdata combinationally, in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select: 0 data, 1 pointer low, 2 pointer high and mode, 3 unused |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register |

## Verification
A wrong pointer shows up at the first data read after the fault, because the returned byte no longer matches the byte written at the expected address. The pointer registers also show a wrong value as soon as the host reads them back. A lost or misdirected commit only appears when that address is read later, so every written byte is read back both in order and by random pointer loads. A prefetch that fires when it should not, or fails to fire, changes the data register value seen two cycles after the pointer load.

// File: rtl/bufram_pkg.sv
package bufram_pkg;
  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_NONE   = 2'd3
  } host_sel_e;

  // mode bit positions inside the pointer-high register
  localparam int unsigned MODE_STEP_BIT = 7;
  localparam int unsigned MODE_RDIR_BIT = 6;
endpackage

// File: rtl/bufram_mem.sv
module bufram_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] arr [DEPTH];
  logic              rd_en;

  assign rd_en = en & ~we;

  always_ff @(posedge clk) begin
    if (en && we) begin
      arr[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (rd_en) begin
      q <= arr[addr];
    end
  end
endmodule

// File: rtl/bufram_ptr.sv
module bufram_ptr
  import bufram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic              step_en,
  output logic              rd_dir
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;
  logic              step_now;

  assign step_now = adv & step_en & ~lo_we & ~hi_we;
  assign ptr_en   = lo_we | hi_we | step_now;

  // host loads win over a step in the same cycle
  always_comb begin
    ptr_d = ptr;
    if (lo_we) begin
      ptr_d[DATA_W-1:0] = wdata;
    end
    if (hi_we) begin
      ptr_d[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
    end
    if (step_now) begin
      ptr_d = ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_en <= 1'b0;
      rd_dir  <= 1'b0;
    end else if (hi_we) begin
      step_en <= wdata[MODE_STEP_BIT];
      rd_dir  <= wdata[MODE_RDIR_BIT];
    end
  end
endmodule

// File: rtl/bufram_seq.sv
module bufram_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic              fetch_trig,
  input  logic              step_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ram_en,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              adv,
  output logic [DATA_W-1:0] data_view
);
  logic              pf_req, pf_req_d;
  logic              wb_pend, wb_pend_d;
  logic              fetch_vld, fetch_vld_d;
  logic [DATA_W-1:0] dreg, dreg_d;
  logic              dreg_en;
  logic              rd_now;

  // commit has priority; a blocked fetch waits one cycle
  assign rd_now = pf_req & ~wb_pend;

  always_comb begin
    pf_req_d    = fetch_trig | (dat_rd & step_en) | (pf_req & wb_pend);
    wb_pend_d   = dat_wr;
    fetch_vld_d = rd_now;
    dreg_en     = dat_wr | fetch_vld;
    dreg_d      = dat_wr ? wdata : ram_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_req    <= 1'b0;
      wb_pend   <= 1'b0;
      fetch_vld <= 1'b0;
    end else begin
      pf_req    <= pf_req_d;
      wb_pend   <= wb_pend_d;
      fetch_vld <= fetch_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg <= '0;
    end else if (dreg_en) begin
      dreg <= dreg_d;
    end
  end

  assign ram_en    = wb_pend | rd_now;
  assign ram_we    = wb_pend;
  assign ram_wdata = dreg;
  assign adv       = dat_rd | wb_pend;
  // bypass the freshly fetched byte so it is readable without an extra cycle
  assign data_view = fetch_vld ? ram_q : dreg;
endmodule

// File: rtl/bufram_port.sv
module bufram_port
  import bufram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  host_sel_e         sel;
  logic              dat_rd, dat_wr, lo_we, hi_we, fetch_trig;
  logic [ADDR_W-1:0] ptr;
  logic              step_en, rd_dir, adv;
  logic              ram_en, ram_we;
  logic [DATA_W-1:0] ram_q, ram_wdata, data_view, hi_view;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign sel        = host_sel_e'(host_addr);
  assign dat_rd     = host_rd & (sel == SEL_DATA);
  assign dat_wr     = host_wr & (sel == SEL_DATA);
  assign lo_we      = host_wr & (sel == SEL_PTR_LO);
  assign hi_we      = host_wr & (sel == SEL_PTR_HI);
  assign fetch_trig = lo_we & rd_dir;

  bufram_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .wdata   (host_wdata),
    .adv     (adv),
    .ptr     (ptr),
    .step_en (step_en),
    .rd_dir  (rd_dir)
  );

  bufram_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dat_rd     (dat_rd),
    .dat_wr     (dat_wr),
    .fetch_trig (fetch_trig),
    .step_en    (step_en),
    .wdata      (host_wdata),
    .ram_q      (ram_q),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .adv        (adv),
    .data_view  (data_view)
  );

  bufram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ptr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );

  always_comb begin
    hi_view                = '0;
    hi_view[HI_W-1:0]      = ptr[ADDR_W-1:DATA_W];
    hi_view[MODE_STEP_BIT] = step_en;
    hi_view[MODE_RDIR_BIT] = rd_dir;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:   host_rdata = data_view;
      SEL_PTR_LO: host_rdata = ptr[DATA_W-1:0];
      SEL_PTR_HI: host_rdata = hi_view;
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bufram_port_chk.sv
module bufram_port_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] ptr,
  input logic              step_en,
  input logic              rd_dir,
  input logic              ram_en,
  input logic              ram_we
);
  AST_PREFETCH_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && rd_dir) |=> (ram_en && !ram_we)); // R3

  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !host_wr) |=> $stable(ptr)); // R4

  AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0) |=> (ram_en && ram_we)); // R5

  AST_STEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && host_rd && !host_wr && host_addr == 2'd0)
      |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R7

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && host_rd && !host_wr && host_addr == 2'd0 && ptr == {ADDR_W{1'b1}})
      |=> (ptr == '0)); // R8
endmodule

bind bufram_port bufram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .ptr       (ptr),
  .step_en   (step_en),
  .rd_dir    (rd_dir),
  .ram_en    (ram_en),
  .ram_we    (ram_we)
);

// File: tb/sim_bufram_port.sv
module sim_bufram_port;
  logic       clk;
  logic       rst_n;
  logic [1:0] host_addr;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;

  int n_cmp;
  int n_bad;
  bit done;
  logic [7:0] refm [2048];

  bufram_port u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  // value is sampled inside the strobe cycle (R10)
  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_rd   = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd   = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] mode, input int unsigned a);
    bus_wr(2'd2, mode | 8'(a >> 8));
    bus_wr(2'd1, 8'(a));
  endtask

  task automatic get_ptr(output logic [10:0] p);
    logic [7:0] lo, hi;
    bus_rd(2'd1, lo);
    bus_rd(2'd2, hi);
    p = {hi[2:0], lo};
  endtask

  function automatic logic [7:0] pat(int unsigned i, int unsigned seed);
    return 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      bus_rd(2'(s), v);
      check("R1 reset value", 16'(v), 16'h00);
    end
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, v);
    check("R2 high register bits", 16'(v), 16'hC7);
    bus_wr(2'd1, 8'h5A);
    bus_rd(2'd1, v);
    check("R2 low register", 16'(v), 16'h5A);
    bus_rd(2'd3, v);
    check("R2 unused select", 16'(v), 16'h00);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd2, v);
    check("R2 high register cleared", 16'(v), 16'h00);
  endtask

  task automatic t_seq_load(input int unsigned base, input int unsigned n, input int unsigned seed);
    logic [10:0] p;
    set_ptr(8'h80, base);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = pat(i, seed);
      bus_wr(2'd0, b);
      refm[(base + i) % 2048] = b;
    end
    get_ptr(p);
    check("R6 pointer after stepping writes", 16'(p), 16'((base + n) % 2048));
  endtask

  task automatic t_seq_read(input int unsigned base, input int unsigned n);
    logic [10:0] p;
    logic [7:0]  v;
    set_ptr(8'hC0, base);
    for (int i = 0; i < n; i++) begin
      bus_rd(2'd0, v);
      check("R7 R10 stepping read byte", 16'(v), 16'(refm[(base + i) % 2048]));
    end
    get_ptr(p);
    check("R7 pointer after stepping reads", 16'(p), 16'((base + n) % 2048));
  endtask

  task automatic t_wrap();
    logic [10:0] p;
    t_seq_load(2046, 4, 9);
    get_ptr(p);
    check("R8 pointer wrapped past 2047", 16'(p), 16'd2);
    t_seq_read(2046, 4);
  endtask

  task automatic t_random_read();
    int unsigned addrs [6] = '{16'h105, 16'h13E, 16'h100, 16'h0FA, 16'h121, 16'h7FF};
    logic [7:0]  v1, v2;
    logic [10:0] p;
    foreach (addrs[k]) begin
      set_ptr(8'h40, addrs[k]);
      bus_rd(2'd0, v1);
      check("R3 prefetch after pointer load", 16'(v1), 16'(refm[addrs[k]]));
      bus_rd(2'd0, v2);
      check("R4 repeat read unchanged", 16'(v2), 16'(refm[addrs[k]]));
      get_ptr(p);
      check("R4 pointer held", 16'(p), 16'(addrs[k]));
    end
  endtask

  task automatic t_random_write();
    int unsigned addrs [4] = '{16'h2A0, 16'h011, 16'h5C3, 16'h110};
    logic [10:0] p;
    logic [7:0]  v;
    foreach (addrs[k]) begin
      logic [7:0] b;
      b = 8'(8'hA5 ^ (k * 29));
      set_ptr(8'h00, addrs[k]);
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd0, b);
      refm[addrs[k]] = b;
      get_ptr(p);
      check("R5 pointer held on write", 16'(p), 16'(addrs[k]));
    end
    foreach (addrs[k]) begin
      set_ptr(8'h40, addrs[k]);
      bus_rd(2'd0, v);
      check("R5 committed byte", 16'(v), 16'(refm[addrs[k]]));
    end
  endtask

  task automatic t_no_fetch();
    logic [7:0]  v;
    logic [10:0] p;
    set_ptr(8'h40, 16'h102);
    bus_rd(2'd0, v);
    check("R3 fetch before direction change", 16'(v), 16'(refm[16'h102]));
    set_ptr(8'h00, 16'h130);
    bus_rd(2'd0, v);
    check("R9 no fetch in write direction", 16'(v), 16'(refm[16'h102]));
    get_ptr(p);
    check("R9 pointer loaded", 16'(p), 16'h130);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done = 1'b0;
    host_addr = '0;
    host_wr = 1'b0;
    host_rd = 1'b0;
    host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_regs();
    t_seq_load(16'h100, 64, 1);
    t_seq_load(16'h0F8, 8, 2);
    t_seq_read(16'h0F8, 72);
    t_wrap();
    t_random_read();
    t_random_write();
    t_no_fetch();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule